// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles. A one-cycle `start_i` pulse, taken only while the unit is idle, captures the dividend, the divisor and the mode. In signed mode the unit works on the operand magnitudes. A single double-width working register holds the partial remainder in its upper half and the dividend in its lower half. On each iteration it shifts that register left by one, tries a subtraction of the divisor against the upper half, and shifts the resulting quotient bit into the bottom of the register.

After the last iteration, one correction cycle applies signs in signed mode. The quotient is then placed on `lo_o` and the remainder on `hi_o`, and `done_o` pulses for one cycle. A zero divisor raises `div_by_zero_o`, but nothing traps and nothing is corrected. Quotient overflow is not detected. Software that issues the divide must screen both cases itself.

Top module: `seq_divider`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `done_o`, `div_by_zero_o`, `lo_o` and `hi_o` are all zero.
- R2: `start_i` is accepted only on a rising edge where `busy_o` is low. `busy_o` is high from the next cycle until the cycle `done_o` is high, when it is low again. A `start_i` seen while `busy_o` is high is ignored: the running result is unchanged and no extra `done_o` follows.
- R3: `done_o` rises on the 33rd rising edge after the edge that accepted `start_i` (W iterations plus one correction) and stays high for exactly one cycle.
- R4: With `signed_i` = 0, `lo_o` = floor(dividend / divisor) and `hi_o` = dividend mod divisor, both taken as unsigned numbers.
- R5: With `signed_i` = 1, operands are in two's complement. The quotient truncates toward zero and is negative exactly when the operand signs differ and its magnitude is nonzero.
- R6: With `signed_i` = 1, a nonzero remainder has the sign of the dividend. A zero remainder is all zeros. dividend = quotient × divisor + remainder holds.
- R7: A zero divisor sets `div_by_zero_o` to 1 with the result, and to 0 otherwise. For a zero divisor the sign correction is skipped: `lo_o` is all ones and `hi_o` is the dividend's magnitude (the dividend itself in unsigned mode).
- R8: The signed case -2^31 / -1 returns `lo_o` = 0x80000000 and `hi_o` = 0, with `div_by_zero_o` = 0 and no other indication.
- R9: `lo_o`, `hi_o` and `div_by_zero_o` change only on the edge that raises `done_o`, and hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division (taken when idle) |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| div_by_zero_o | output | 1 | Divisor of the last result was zero |
| lo_o | output | 32 | Quotient |
| hi_o | output | 32 | Remainder |

## Verification
The bench drives each sign combination of operands whose remainder is nonzero. A design that negates the remainder by the divisor's sign, or that negates the quotient on the wrong condition, breaks dividend = quotient × divisor + remainder there. It also targets corner cases:
- -2^31 / -1, where a design that computes magnitudes in too few bits produces a wrong quotient.
- Dividends with the top bit set in unsigned mode, where a trial subtraction that drops the bit shifted out of the remainder gives a wrong quotient.
- Zero divisors in both modes, where a design that applies the sign correction anyway corrupts the raw result.

A `start_i` pulse issued mid-run checks that the running operation is not restarted or corrupted. Exact `done_o` latency checks catch an iteration count that is off by one.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         q_neg_o,
  output logic         r_neg_o,
  output logic         dvs_zero_o
);
  logic dvd_s, dvs_s;

  assign dvd_s = signed_i & dividend_i[W-1];
  assign dvs_s = signed_i & divisor_i[W-1];

  // -2^(W-1) negates to itself, which is its correct unsigned magnitude
  assign dvd_mag_o  = dvd_s ? (~dividend_i + 1'b1) : dividend_i;
  assign dvs_mag_o  = dvs_s ? (~divisor_i + 1'b1) : divisor_i;
  assign q_neg_o    = dvd_s ^ dvs_s;
  assign r_neg_o    = dvd_s;
  assign dvs_zero_o = (divisor_i == '0);
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] rem_o
);
  // trial operand keeps the bit shifted out of the top half (W+1 bits)
  logic [W+1:0] diff;

  assign diff = {1'b0, rem_i[2*W-1:W-1]} - {2'b00, dvs_i};

  always_comb begin
    if (diff[W+1]) rem_o = {rem_i[2*W-2:0], 1'b0};
    else           rem_o = {diff[W-1:0], rem_i[W-2:0], 1'b1};
  end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_i,
  input  logic           q_neg_i,
  input  logic           r_neg_i,
  input  logic           bypass_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o
);
  logic [W-1:0] q_mag, r_mag;
  logic         q_nz, r_nz;

  assign q_mag = rem_i[W-1:0];
  assign r_mag = rem_i[2*W-1:W];
  assign q_nz  = |q_mag;
  assign r_nz  = |r_mag;

  always_comb begin
    lo_o = q_mag;
    hi_o = r_mag;
    if (!bypass_i) begin
      if (q_neg_i && q_nz) lo_o = ~q_mag + 1'b1;
      if (r_neg_i && r_nz) hi_o = ~r_mag + 1'b1;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_by_zero_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  import div_pkg::*;

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(W - 1);

  div_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2*W-1:0] rem_q, rem_nxt;
  logic [W-1:0]   dvs_q;
  logic           q_neg_q, r_neg_q, dbz_q;
  logic           done_q, dbz_out_q;
  logic [W-1:0]   lo_q, hi_q;

  logic [W-1:0]   dvd_mag, dvs_mag;
  logic           q_neg, r_neg, dvs_zero;
  logic [W-1:0]   lo_fix, hi_fix;
  logic           accept;

  div_operand_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .q_neg_o    (q_neg),
    .r_neg_o    (r_neg),
    .dvs_zero_o (dvs_zero)
  );

  div_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .dvs_i (dvs_q),
    .rem_o (rem_nxt)
  );

  div_sign_fix #(.W(W)) u_fix (
    .rem_i    (rem_q),
    .q_neg_i  (q_neg_q),
    .r_neg_i  (r_neg_q),
    .bypass_i (dbz_q),
    .lo_o     (lo_fix),
    .hi_o     (hi_fix)
  );

  assign accept = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      q_neg_q <= 1'b0;
      r_neg_q <= 1'b0;
      dbz_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ITER;
          cnt_q   <= '0;
          rem_q   <= {{W{1'b0}}, dvd_mag};
          dvs_q   <= dvs_mag;
          q_neg_q <= q_neg;
          r_neg_q <= r_neg;
          dbz_q   <= dvs_zero;
        end
        ST_ITER: begin
          rem_q <= rem_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IT) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      dbz_out_q <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else begin
      done_q <= (state_q == ST_FIX);
      if (state_q == ST_FIX) begin
        lo_q      <= lo_fix;
        hi_q      <= hi_fix;
        dbz_out_q <= dbz_q;
      end
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign div_by_zero_o = dbz_out_q;
  assign lo_o          = lo_q;
  assign hi_o          = hi_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         div_by_zero_o,
  input logic [W-1:0] lo_o,
  input logic [W-1:0] hi_o
);
  logic         trk_q, sgn_q;
  logic [7:0]   cnt_q;
  logic [W-1:0] dvd_q, dvs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q <= 1'b0;
      cnt_q <= '0;
      sgn_q <= 1'b0;
      dvd_q <= '0;
      dvs_q <= '0;
    end else if (start_i && !busy_o) begin
      trk_q <= 1'b1;
      cnt_q <= '0;
      sgn_q <= signed_i;
      dvd_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (done_o) begin
      trk_q <= 1'b0;
    end else if (trk_q && cnt_q != 8'hff) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_done_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (trk_q && cnt_q == 8'(W + 1)));
  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_at_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(lo_o) && $stable(hi_o) && $stable(div_by_zero_o)));
  p_urem_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_q && !div_by_zero_o) |-> (hi_o < dvs_q));
  p_rem_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sgn_q && !div_by_zero_o && hi_o != '0) |-> (hi_o[W-1] == dvd_q[W-1]));
  p_dbz_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_by_zero_o == (dvs_q == '0)));
  p_dbz_quot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_by_zero_o) |-> (lo_o == '1));
endmodule

bind seq_divider div_checker #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .signed_i      (signed_i),
  .dividend_i    (dividend_i),
  .divisor_i     (divisor_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .div_by_zero_o (div_by_zero_o),
  .lo_o          (lo_o),
  .hi_o          (hi_o)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o, div_by_zero_o;
  logic [31:0] lo_o, hi_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  seq_divider #(.W(32)) u0 (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act %0d exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {signed, dividend, divisor, quotient, remainder, div_by_zero}
  localparam int NV = 14;
  localparam logic [129:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7,        32'd14,       32'd2,        1'b0}, // R4
    {1'b0, 32'hFFFFFFFF,   32'd1,        32'hFFFFFFFF, 32'd0,        1'b0}, // R4
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF, 32'd1,        32'd0,        1'b0}, // R4
    {1'b0, 32'd5,          32'd10,       32'd0,        32'd5,        1'b0}, // R4
    {1'b0, 32'h80000000,   32'd3,        32'h2AAAAAAA, 32'd2,        1'b0}, // R4
    {1'b0, 32'hFFFFFFF9,   32'd2,        32'h7FFFFFFC, 32'd1,        1'b0}, // R4
    {1'b1, 32'd7,          32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1,        1'b0}, // R5
    {1'b1, 32'hFFFFFFF9,   32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF, 1'b0}, // R6
    {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE, 32'd3,        32'hFFFFFFFF, 1'b0}, // R6
    {1'b1, 32'hFFFFFFF8,   32'd2,        32'hFFFFFFFC, 32'd0,        1'b0}, // R6
    {1'b1, 32'd0,          32'hFFFFFFFB, 32'd0,        32'd0,        1'b0}, // R5
    {1'b1, 32'h80000000,   32'hFFFFFFFF, 32'h80000000, 32'd0,        1'b0}, // R8
    {1'b0, 32'd123,        32'd0,        32'hFFFFFFFF, 32'd123,      1'b1}, // R7
    {1'b1, 32'hFFFFFFF8,   32'd0,        32'hFFFFFFFF, 32'd8,        1'b1}  // R7
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  // drives one op, returns negedges from start to done
  task automatic run_op(input logic sgn, input logic [31:0] a, input logic [31:0] b, output int lat);
    @(negedge clk_i);
    signed_i = sgn; dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [31:0] lo_hold, hi_hold;
    // R1 reset
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, div_by_zero_o} == 3'b000, "R1 reset flags", 32'({busy_o, done_o, div_by_zero_o}), 32'd0);
    chk(lo_o == 0 && hi_o == 0, "R1 reset data", lo_o | hi_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 after release", 32'({busy_o, done_o}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [129:0] v;
      v = VEC[i];
      run_op(v[129], v[128:97], v[96:65], lat);
      chk(lat == 34, "R3 latency", 32'(lat), 32'd34);
      chk(lo_o == v[64:33], "R4/R5/R7/R8 quotient", lo_o, v[64:33]);
      chk(hi_o == v[32:1], "R4/R6/R7/R8 remainder", hi_o, v[32:1]);
      chk(div_by_zero_o == v[0], "R7 flag", 32'(div_by_zero_o), 32'(v[0]));
      chk(!busy_o, "R2 idle at done", 32'(busy_o), 32'd0);
      @(negedge clk_i);
      chk(!done_o, "R3 single cycle done", 32'(done_o), 32'd0);
    end

    // R9 hold: last result (-8/0 signed) stays
    lo_hold = lo_o; hi_hold = hi_o;
    repeat (10) @(negedge clk_i);
    chk(lo_o == lo_hold && hi_o == hi_hold && div_by_zero_o, "R9 hold", lo_o, lo_hold);

    // R2 start ignored while busy
    @(negedge clk_i);
    signed_i = 1'b0; dividend_i = 32'd100; divisor_i = 32'd7; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    signed_i = 1'b1; dividend_i = 32'd1; divisor_i = 32'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    dividend_i = 32'd9; divisor_i = 32'd9;
    lat = 7;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    chk(lat == 34, "R2 latency unaffected", 32'(lat), 32'd34);
    chk(lo_o == 32'd14 && hi_o == 32'd2 && !div_by_zero_o, "R2 result unaffected", lo_o, 32'd14);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (done_o) lat++;
    end
    chk(lat == 0, "R2 no extra done", 32'(lat), 32'd0);
    chk(lo_o == 32'd14 && hi_o == 32'd2, "R9 hold after ignored start", hi_o, 32'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule